// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state of a bank of interrupt sources and turns source activity into delivery requests for a downstream presentation unit. Each source is either level-sensitive or message-style, as set by a strap input. Each source holds a destination server, a priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. The priority value 0xFF masks a source.

Sources are addressed externally by a number that starts at a fixed base. The presentation unit talks back through three one-cycle notices. A reject notice names a source it turned away. An end-of-interrupt notice names a source it has finished with. A resend request asks the block to offer again everything that is still outstanding. A configuration port carries four commands: set, get, disable and enable. Each command is answered with a status code one cycle later. Deliveries leave through a valid/ready handshake, and each one carries the source number, the server and the priority.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset every source has priority 0xFF, saved priority 0xFF, server 0 and all flags clear. No delivery is offered, no scan is running and no response is valid.
- R2: A source number is valid only within BASE to BASE+N-1, and its index is the number minus BASE. Every command with an invalid number answers status 0xFD (-3 in 8-bit two's complement). Every accepted command answers 0x00.
- R3: Set (op 0) is refused with 0xFD if the server is NUM_SERVERS or more, or if the priority argument exceeds 255. Otherwise it stores the server and writes the priority into both the priority and the saved priority.
- R4: The response appears exactly one cycle after the command. Get (op 1) returns the server and priority of a valid source. Every other command returns 0 in those fields.
- R5: Disable (op 2) sets the priority to 0xFF and stores the previous priority as the saved priority. Enable (op 3) copies the saved priority into both fields. The server is kept in both cases.
- R6: A rising line on a message source with priority other than 0xFF delivers {number, server, priority}. A falling line on a message source does nothing.
- R7: A rising line on a masked message source sets masked-pending and delivers nothing. The next configuration write that leaves the priority other than 0xFF clears the flag and delivers once.
- R8: On a level source the asserted flag follows the line. After a line change, a configuration write or a scan visit, a level source that is asserted, unmasked and not yet sent sets sent and delivers.
- R9: A reject notice sets rejected and clears sent on either source type.
- R10: An end-of-interrupt notice clears sent on level sources only, and it never delivers by itself.
- R11: A resend request starts a scan that holds scanBusy high for exactly N cycles and visits one source per cycle. A visited message source that is rejected has rejected cleared and is redelivered if it is unmasked. A visited level source applies the rule of R8. A resend request during a scan is ignored.
- R12: A delivery is held with stable fields while dlvReady is low. When several sources are waiting, they leave lowest index first.
- R13: Reject and end-of-interrupt notices with an invalid number change no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLine | input | NUM_SRC | Source request lines |
| srcIsLevel | input | NUM_SRC | Per-source type strap, 1 = level, 0 = message |
| cfgValid | input | 1 | Configuration command strobe |
| cfgOp | input | 2 | 0 set, 1 get, 2 disable, 3 enable |
| cfgNum | input | NUM_W | Source number argument |
| cfgServer | input | SRV_ARG_W | Server argument (set) |
| cfgPrio | input | PRIO_ARG_W | Priority argument (set) |
| rspValid | output | 1 | Response strobe |
| rspStatus | output | 8 | 0x00 accepted, 0xFD refused |
| rspServer | output | SRV_W | Server returned by get |
| rspPrio | output | 8 | Priority returned by get |
| rejValid | input | 1 | Reject notice |
| rejNum | input | NUM_W | Source number of the reject |
| eoiValid | input | 1 | End-of-interrupt notice |
| eoiNum | input | NUM_W | Source number of the end-of-interrupt |
| resendReq | input | 1 | Resend request |
| scanBusy | output | 1 | Resend scan in progress |
| dlvValid | output | 1 | Delivery offered |
| dlvReady | input | 1 | Delivery accepted |
| dlvNum | output | NUM_W | Delivered source number |
| dlvServer | output | SRV_W | Destination server |
| dlvPrio | output | 8 | Delivered priority |

## Verification
The flag assertions take for granted that the type strap is fixed while out of reset. A sent flag on a message source, or masked-pending on a source that is not masked, can only come about if the strap changes under a source that already has state. The stimulus therefore sets the strap once before reset and never touches it. It sweeps the set command across out-of-range numbers, servers and priorities with every line low, so that the configuration checks run with no deliveries in flight. The notices and requests that drive the resend paths are always single-cycle pulses. The handshake hold assertion makes no assumption about dlvReady, and the bench deliberately holds it low across queued deliveries.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int NUM_SRC     = 8;
  localparam int SRC_BASE    = 32;
  localparam int NUM_SERVERS = 4;
  localparam int NUM_W       = 12;
  localparam int SRV_ARG_W   = 8;
  localparam int PRIO_ARG_W  = 16;
  localparam int PRIO_W      = 8;
  localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int SRV_W       = (NUM_SERVERS > 1) ? $clog2(NUM_SERVERS) : 1;

  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;
  localparam logic [7:0]        ST_OK       = 8'h00;
  localparam logic [7:0]        ST_BAD      = 8'hFD;

  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_GET = 2'd1,
    OP_OFF = 2'd2,
    OP_ON  = 2'd3
  } cfg_op_e;

  // bit 0 asserted, bit 1 sent, bit 2 rejected, bit 3 masked-pending
  typedef struct packed {
    logic maskedPend;
    logic rejected;
    logic sent;
    logic asserted;
  } src_flags_t;

  // strobes from control into the source table
  typedef struct packed {
    logic              cfgWr;
    logic [IDX_W-1:0]  cfgIdx;
    logic [SRV_W-1:0]  cfgSrv;
    logic [PRIO_W-1:0] cfgPrio;
    logic [PRIO_W-1:0] cfgSaved;
    logic              scanHit;
    logic [IDX_W-1:0]  scanIdx;
    logic              rejHit;
    logic [IDX_W-1:0]  rejIdx;
    logic              eoiHit;
    logic [IDX_W-1:0]  eoiIdx;
    logic              issue;
    logic [IDX_W-1:0]  issueIdx;
  } tbl_strobe_t;

  function automatic logic numInRange(input logic [NUM_W-1:0] n);
    return (n >= NUM_W'(SRC_BASE)) && (n < NUM_W'(SRC_BASE + NUM_SRC));
  endfunction

  function automatic logic [IDX_W-1:0] numToIdx(input logic [NUM_W-1:0] n);
    return IDX_W'(n - NUM_W'(SRC_BASE));
  endfunction

  function automatic logic [NUM_W-1:0] idxToNum(input logic [IDX_W-1:0] i);
    return NUM_W'(SRC_BASE) + NUM_W'(i);
  endfunction
endpackage

// File: rtl/isc_source_table.sv
module isc_source_table
  import isc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0]                srcLine,
  input  logic [NUM_SRC-1:0]                srcIsLevel,
  input  tbl_strobe_t                       strb,
  output logic [NUM_SRC-1:0][SRV_W-1:0]     srvTab,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prioTab,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    savedTab,
  output logic [NUM_SRC-1:0]                want
);
  logic [NUM_SRC-1:0] prevLine;

  always_ff @(posedge clk) begin
    if (!rstN) prevLine <= '0;
    else       prevLine <= srcLine;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    src_flags_t        flagsQ, flagsD;
    logic [SRV_W-1:0]  srvQ, srvD;
    logic [PRIO_W-1:0] prioQ, prioD, savedQ, savedD;
    logic              wantQ, wantD;
    logic              isLvl, rise, chg;
    logic              cfgHit, scanHitI, rejHitI, eoiHitI, issueHitI, dlv;

    assign isLvl     = srcIsLevel[i];
    assign rise      = srcLine[i] & ~prevLine[i];
    assign chg       = srcLine[i] ^ prevLine[i];
    assign cfgHit    = strb.cfgWr   && (strb.cfgIdx   == IDX_W'(i));
    assign scanHitI  = strb.scanHit && (strb.scanIdx  == IDX_W'(i));
    assign rejHitI   = strb.rejHit  && (strb.rejIdx   == IDX_W'(i));
    assign eoiHitI   = strb.eoiHit  && (strb.eoiIdx   == IDX_W'(i));
    assign issueHitI = strb.issue   && (strb.issueIdx == IDX_W'(i));

    always_comb begin
      flagsD = flagsQ;
      srvD   = srvQ;
      prioD  = prioQ;
      savedD = savedQ;
      dlv    = 1'b0;
      // line activity
      if (isLvl) begin
        if (chg) flagsD.asserted = srcLine[i];
      end else if (rise) begin
        if (prioQ == PRIO_MASKED) flagsD.maskedPend = 1'b1;
        else                      dlv = 1'b1;
      end
      // notices from the presentation unit
      if (rejHitI) begin
        flagsD.rejected = 1'b1;
        flagsD.sent     = 1'b0;
      end
      if (eoiHitI && isLvl) flagsD.sent = 1'b0;
      // configuration write
      if (cfgHit) begin
        srvD   = strb.cfgSrv;
        prioD  = strb.cfgPrio;
        savedD = strb.cfgSaved;
        if (!isLvl && flagsD.maskedPend && (strb.cfgPrio != PRIO_MASKED)) begin
          flagsD.maskedPend = 1'b0;
          dlv = 1'b1;
        end
      end
      // resend scan visit, message side
      if (scanHitI && !isLvl && flagsD.rejected) begin
        flagsD.rejected = 1'b0;
        if (prioD != PRIO_MASKED) dlv = 1'b1;
      end
      // level offer rule, once per cycle after all updates
      if (isLvl && (chg || cfgHit || scanHitI) && (prioD != PRIO_MASKED)
          && flagsD.asserted && !flagsD.sent) begin
        flagsD.sent = 1'b1;
        dlv = 1'b1;
      end
      wantD = (wantQ && !issueHitI) || dlv;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagsQ <= '0;
        srvQ   <= '0;
        prioQ  <= PRIO_MASKED;
        savedQ <= PRIO_MASKED;
        wantQ  <= 1'b0;
      end else begin
        flagsQ <= flagsD;
        srvQ   <= srvD;
        prioQ  <= prioD;
        savedQ <= savedD;
        wantQ  <= wantD;
      end
    end

    assign srvTab[i]   = srvQ;
    assign prioTab[i]  = prioQ;
    assign savedTab[i] = savedQ;
    assign want[i]     = wantQ;

    AST_PEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rstN)
      flagsQ.maskedPend |-> (prioQ == PRIO_MASKED)); // R7
    AST_MSG_NEVER_SENT: assert property (@(posedge clk) disable iff (!rstN)
      !isLvl |-> !flagsQ.sent); // R10
  end
endmodule

// File: rtl/isc_control.sv
module isc_control
  import isc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgValid,
  input  logic [1:0]                     cfgOp,
  input  logic [NUM_W-1:0]               cfgNum,
  input  logic [SRV_ARG_W-1:0]           cfgServer,
  input  logic [PRIO_ARG_W-1:0]          cfgPrio,
  output logic                           rspValid,
  output logic [7:0]                     rspStatus,
  output logic [SRV_W-1:0]               rspServer,
  output logic [PRIO_W-1:0]              rspPrio,
  input  logic                           rejValid,
  input  logic [NUM_W-1:0]               rejNum,
  input  logic                           eoiValid,
  input  logic [NUM_W-1:0]               eoiNum,
  input  logic                           resendReq,
  output logic                           scanBusy,
  output logic                           dlvValid,
  input  logic                           dlvReady,
  output logic [NUM_W-1:0]               dlvNum,
  output logic [SRV_W-1:0]               dlvServer,
  output logic [PRIO_W-1:0]              dlvPrio,
  input  logic [NUM_SRC-1:0][SRV_W-1:0]  srvTab,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] savedTab,
  input  logic [NUM_SRC-1:0]             want,
  output tbl_strobe_t                    strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  cfg_op_e           op;
  logic              numOk, cmdOk, cmdWr;
  logic [IDX_W-1:0]  cIdx;
  logic [SRV_W-1:0]  wrSrv;
  logic [PRIO_W-1:0] wrPrio, wrSaved;
  logic [IDX_W-1:0]  scanIdx;
  logic              slotFree, pickAny;
  logic [IDX_W-1:0]  pickIdx;

  assign op    = cfg_op_e'(cfgOp);
  assign numOk = numInRange(cfgNum);
  assign cIdx  = numToIdx(cfgNum);

  // command decode and argument checks
  always_comb begin
    cmdOk   = numOk;
    cmdWr   = 1'b0;
    wrSrv   = srvTab[cIdx];
    wrPrio  = prioTab[cIdx];
    wrSaved = savedTab[cIdx];
    case (op)
      OP_SET: begin
        cmdOk   = numOk && (cfgServer < SRV_ARG_W'(NUM_SERVERS))
                        && (cfgPrio <= PRIO_ARG_W'(255));
        cmdWr   = cmdOk;
        wrSrv   = SRV_W'(cfgServer);
        wrPrio  = PRIO_W'(cfgPrio);
        wrSaved = PRIO_W'(cfgPrio);
      end
      OP_OFF: begin
        cmdWr   = numOk;
        wrPrio  = PRIO_MASKED;
        wrSaved = prioTab[cIdx];
      end
      OP_ON: begin
        cmdWr   = numOk;
        wrPrio  = savedTab[cIdx];
      end
      default: cmdWr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspStatus <= ST_OK;
      rspServer <= '0;
      rspPrio   <= '0;
    end else begin
      rspValid  <= cfgValid;
      if (cfgValid) begin
        rspStatus <= cmdOk ? ST_OK : ST_BAD;
        rspServer <= (op == OP_GET && cmdOk) ? srvTab[cIdx]  : '0;
        rspPrio   <= (op == OP_GET && cmdOk) ? prioTab[cIdx] : '0;
      end
    end
  end

  // resend scan, one source per cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanBusy <= 1'b0;
      scanIdx  <= '0;
    end else if (!scanBusy) begin
      if (resendReq) begin
        scanBusy <= 1'b1;
        scanIdx  <= '0;
      end
    end else if (scanIdx == LAST_IDX) begin
      scanBusy <= 1'b0;
    end else begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  // lowest waiting index wins the output slot
  always_comb begin
    pickAny = 1'b0;
    pickIdx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (want[k]) begin
        pickAny = 1'b1;
        pickIdx = IDX_W'(k);
      end
    end
  end

  assign slotFree = !dlvValid || dlvReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlvValid  <= 1'b0;
      dlvNum    <= '0;
      dlvServer <= '0;
      dlvPrio   <= '0;
    end else if (slotFree && pickAny) begin
      dlvValid  <= 1'b1;
      dlvNum    <= idxToNum(pickIdx);
      dlvServer <= srvTab[pickIdx];
      dlvPrio   <= prioTab[pickIdx];
    end else if (dlvReady) begin
      dlvValid  <= 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.cfgWr    = cfgValid && cmdWr;
    strb.cfgIdx   = cIdx;
    strb.cfgSrv   = wrSrv;
    strb.cfgPrio  = wrPrio;
    strb.cfgSaved = wrSaved;
    strb.scanHit  = scanBusy;
    strb.scanIdx  = scanIdx;
    strb.rejHit   = rejValid && numInRange(rejNum);
    strb.rejIdx   = numToIdx(rejNum);
    strb.eoiHit   = eoiValid && numInRange(eoiNum);
    strb.eoiIdx   = numToIdx(eoiNum);
    strb.issue    = slotFree && pickAny;
    strb.issueIdx = pickIdx;
  end

  AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid && !dlvReady |=> dlvValid && $stable(dlvNum) && $stable(dlvServer) && $stable(dlvPrio)); // R12
  AST_DLV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> numInRange(dlvNum)); // R6
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    scanBusy && (scanIdx != LAST_IDX) |=> scanBusy && (scanIdx == $past(scanIdx) + 1'b1)); // R11
  AST_SCAN_END: assert property (@(posedge clk) disable iff (!rstN)
    scanBusy && (scanIdx == LAST_IDX) |=> !scanBusy); // R11
  AST_RSP_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> rspValid); // R4
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |=> !rspValid); // R4
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspStatus == ST_OK) || (rspStatus == ST_BAD)); // R2
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import isc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcLine,
  input  logic [NUM_SRC-1:0]    srcIsLevel,
  input  logic                  cfgValid,
  input  logic [1:0]            cfgOp,
  input  logic [NUM_W-1:0]      cfgNum,
  input  logic [SRV_ARG_W-1:0]  cfgServer,
  input  logic [PRIO_ARG_W-1:0] cfgPrio,
  output logic                  rspValid,
  output logic [7:0]            rspStatus,
  output logic [SRV_W-1:0]      rspServer,
  output logic [PRIO_W-1:0]     rspPrio,
  input  logic                  rejValid,
  input  logic [NUM_W-1:0]      rejNum,
  input  logic                  eoiValid,
  input  logic [NUM_W-1:0]      eoiNum,
  input  logic                  resendReq,
  output logic                  scanBusy,
  output logic                  dlvValid,
  input  logic                  dlvReady,
  output logic [NUM_W-1:0]      dlvNum,
  output logic [SRV_W-1:0]      dlvServer,
  output logic [PRIO_W-1:0]     dlvPrio
);
  tbl_strobe_t                    strb;
  logic [NUM_SRC-1:0][SRV_W-1:0]  srvTab;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab;
  logic [NUM_SRC-1:0][PRIO_W-1:0] savedTab;
  logic [NUM_SRC-1:0]             want;

  isc_control u_ctl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgOp(cfgOp), .cfgNum(cfgNum),
    .cfgServer(cfgServer), .cfgPrio(cfgPrio),
    .rspValid(rspValid), .rspStatus(rspStatus),
    .rspServer(rspServer), .rspPrio(rspPrio),
    .rejValid(rejValid), .rejNum(rejNum),
    .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendReq(resendReq), .scanBusy(scanBusy),
    .dlvValid(dlvValid), .dlvReady(dlvReady), .dlvNum(dlvNum),
    .dlvServer(dlvServer), .dlvPrio(dlvPrio),
    .srvTab(srvTab), .prioTab(prioTab), .savedTab(savedTab),
    .want(want), .strb(strb)
  );

  isc_source_table u_tbl (
    .clk(clk), .rstN(rstN),
    .srcLine(srcLine), .srcIsLevel(srcIsLevel), .strb(strb),
    .srvTab(srvTab), .prioTab(prioTab), .savedTab(savedTab),
    .want(want)
  );
endmodule

// File: tb/test_irq_source_ctrl.sv
`timescale 1ns/1ps
module test_irq_source_ctrl;
  import isc_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_SRC-1:0] srcLine = '0;
  logic [NUM_SRC-1:0] srcIsLevel = 8'hF0;
  logic cfgValid = 1'b0;
  logic [1:0] cfgOp = '0;
  logic [NUM_W-1:0] cfgNum = '0;
  logic [SRV_ARG_W-1:0] cfgServer = '0;
  logic [PRIO_ARG_W-1:0] cfgPrio = '0;
  logic rspValid;
  logic [7:0] rspStatus;
  logic [SRV_W-1:0] rspServer;
  logic [PRIO_W-1:0] rspPrio;
  logic rejValid = 1'b0;
  logic [NUM_W-1:0] rejNum = '0;
  logic eoiValid = 1'b0;
  logic [NUM_W-1:0] eoiNum = '0;
  logic resendReq = 1'b0;
  logic scanBusy;
  logic dlvValid;
  logic dlvReady = 1'b1;
  logic [NUM_W-1:0] dlvNum;
  logic [SRV_W-1:0] dlvServer;
  logic [PRIO_W-1:0] dlvPrio;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] gStatus;
  logic [31:0] gSrv, gPrio;
  logic gValid;
  int dq[$];

  always #2.5 clk = ~clk;

  irq_source_ctrl i_irq_source_ctrl (
    .clk(clk), .rstN(rstN), .srcLine(srcLine), .srcIsLevel(srcIsLevel),
    .cfgValid(cfgValid), .cfgOp(cfgOp), .cfgNum(cfgNum),
    .cfgServer(cfgServer), .cfgPrio(cfgPrio),
    .rspValid(rspValid), .rspStatus(rspStatus),
    .rspServer(rspServer), .rspPrio(rspPrio),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendReq(resendReq), .scanBusy(scanBusy),
    .dlvValid(dlvValid), .dlvReady(dlvReady), .dlvNum(dlvNum),
    .dlvServer(dlvServer), .dlvPrio(dlvPrio)
  );

  // record every transfer that completes on the coming edge
  always @(negedge clk) begin
    #1;
    if (rstN && dlvValid && dlvReady)
      dq.push_back(int'(dlvNum) * 65536 + int'(dlvServer) * 256 + int'(dlvPrio));
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int op, input int num, input int srv, input int prio);
    @(negedge clk);
    cfgValid = 1'b1; cfgOp = 2'(op); cfgNum = NUM_W'(num);
    cfgServer = SRV_ARG_W'(srv); cfgPrio = PRIO_ARG_W'(prio);
    @(negedge clk);
    cfgValid = 1'b0;
    gValid = rspValid; gStatus = rspStatus;
    gSrv = 32'(rspServer); gPrio = 32'(rspPrio);
  endtask

  task automatic expectDlv(input string tag, input int num, input int srv, input int prio);
    idle(16);
    if (dq.size() == 0) chk(tag, 32'hFFFF_FFFF, 32'(num * 65536 + srv * 256 + prio));
    else chk(tag, 32'(dq.pop_front()), 32'(num * 65536 + srv * 256 + prio));
  endtask

  task automatic expectNone(input string tag);
    idle(16);
    chk(tag, 32'(dq.size()), 0);
    dq.delete();
  endtask

  task automatic setLine(input int i, input logic v);
    @(negedge clk);
    srcLine[i] = v;
  endtask

  task automatic reject(input int num);
    @(negedge clk); rejValid = 1'b1; rejNum = NUM_W'(num);
    @(negedge clk); rejValid = 1'b0;
  endtask

  task automatic eoi(input int num);
    @(negedge clk); eoiValid = 1'b1; eoiNum = NUM_W'(num);
    @(negedge clk); eoiValid = 1'b0;
  endtask

  task automatic resend();
    @(negedge clk); resendReq = 1'b1;
    @(negedge clk); resendReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 no delivery", 32'(dlvValid), 0);
    chk("R1 not busy", 32'(scanBusy), 0);
    chk("R1 no response", 32'(rspValid), 0);
    for (int i = 0; i < NUM_SRC; i++) begin
      cfg(OP_GET, SRC_BASE + i, 0, 0);
      chk("R1 reset prio", gPrio, 32'hFF);
      chk("R1 reset server", gSrv, 0);
      chk("R4 get status", 32'(gStatus), 32'(ST_OK));
      cfg(OP_ON, SRC_BASE + i, 0, 0);          // saved priority reset to 0xFF
      cfg(OP_GET, SRC_BASE + i, 0, 0);
      chk("R1 reset saved prio", gPrio, 32'hFF);
    end

    // R2 R3 R4 sweep of the set command
    for (int num = SRC_BASE - 2; num < SRC_BASE + NUM_SRC + 2; num++) begin
      for (int srv = 0; srv <= NUM_SERVERS; srv++) begin
        for (int pk = 0; pk < 4; pk++) begin
          int pr;
          pr = (pk == 0) ? 0 : (pk == 1) ? 7 : (pk == 2) ? 255 : 256;
          ok = (num >= SRC_BASE) && (num < SRC_BASE + NUM_SRC) &&
               (srv < NUM_SERVERS) && (pr <= 255);
          cfg(OP_SET, num, srv, pr);
          chk("R4 response one cycle", 32'(gValid), 1);
          chk("R3 set status", 32'(gStatus), ok ? 32'(ST_OK) : 32'(ST_BAD));
          chk("R4 set returns zero fields", gSrv + gPrio, 0);
          if (ok) begin
            cfg(OP_GET, num, 0, 0);
            chk("R3 stored server", gSrv, 32'(srv));
            chk("R3 stored prio", gPrio, 32'(pr));
          end
        end
      end
      if (num < SRC_BASE || num >= SRC_BASE + NUM_SRC) begin
        cfg(OP_GET, num, 0, 0); chk("R2 get invalid", 32'(gStatus), 32'(ST_BAD));
        cfg(OP_OFF, num, 0, 0); chk("R2 off invalid", 32'(gStatus), 32'(ST_BAD));
        cfg(OP_ON, num, 0, 0);  chk("R2 on invalid", 32'(gStatus), 32'(ST_BAD));
      end
    end
    expectNone("R3 sweep quiet");

    // working configuration: server i%4, priority i+1
    for (int i = 0; i < NUM_SRC; i++) cfg(OP_SET, SRC_BASE + i, i % NUM_SERVERS, i + 1);

    // R6 message source
    setLine(0, 1'b1);
    expectDlv("R6 msg rise", SRC_BASE, 0, 1);
    setLine(0, 1'b0);
    expectNone("R6 msg fall");

    // R5 R7 masked message
    cfg(OP_OFF, SRC_BASE + 1, 0, 0);
    chk("R5 off status", 32'(gStatus), 32'(ST_OK));
    cfg(OP_GET, SRC_BASE + 1, 0, 0);
    chk("R5 off prio", gPrio, 32'hFF);
    chk("R5 off keeps server", gSrv, 1);
    setLine(1, 1'b1);
    expectNone("R7 masked rise");
    setLine(1, 1'b0);
    cfg(OP_ON, SRC_BASE + 1, 0, 0);
    expectDlv("R7 pending on enable", SRC_BASE + 1, 1, 2);
    cfg(OP_GET, SRC_BASE + 1, 0, 0);
    chk("R5 on restores prio", gPrio, 2);
    cfg(OP_ON, SRC_BASE + 1, 0, 0);
    expectNone("R7 pending cleared");

    // R8 level source
    setLine(4, 1'b1);
    expectDlv("R8 level assert", SRC_BASE + 4, 0, 5);
    setLine(4, 1'b0);
    setLine(4, 1'b1);
    expectNone("R8 sent blocks reoffer");

    // R10 R11 end-of-interrupt then resend
    eoi(SRC_BASE + 4);
    expectNone("R10 eoi alone no delivery");
    resend();
    n = 0;
    while (scanBusy) begin n++; @(negedge clk); end
    chk("R11 scan length", 32'(n), 32'(NUM_SRC));
    expectDlv("R10 level after eoi resend", SRC_BASE + 4, 0, 5);

    // R9 reject on both types
    reject(SRC_BASE + 4);
    resend();
    expectDlv("R9 level reject clears sent", SRC_BASE + 4, 0, 5);
    reject(SRC_BASE);
    resend();
    expectDlv("R11 msg rejected redelivered", SRC_BASE, 0, 1);
    resend();
    expectNone("R11 rejected cleared by scan");

    // R10 eoi on message leaves rejected
    reject(SRC_BASE);
    eoi(SRC_BASE);
    resend();
    expectDlv("R10 msg eoi no effect", SRC_BASE, 0, 1);

    // R13 invalid notices alias nothing
    reject(SRC_BASE + NUM_SRC);
    eoi(SRC_BASE + NUM_SRC + 4);
    resend();
    expectNone("R13 invalid notices ignored");

    // R11 resend during scan ignored
    resend();
    n = 0;
    while (scanBusy) begin
      n++;
      resendReq = (n == 3);
      @(negedge clk);
    end
    resendReq = 1'b0;
    chk("R11 busy resend ignored", 32'(n), 32'(NUM_SRC));
    expectNone("R11 no extra delivery");

    // R12 handshake hold and order
    @(negedge clk);
    dlvReady = 1'b0;
    srcLine[3] = 1'b1;
    srcLine[2] = 1'b1;
    idle(6);
    chk("R12 offer valid", 32'(dlvValid), 1);
    chk("R12 lowest first", 32'(dlvNum), 32'(SRC_BASE + 2));
    idle(4);
    chk("R12 held num", 32'(dlvNum), 32'(SRC_BASE + 2));
    chk("R12 held prio", 32'(dlvPrio), 3);
    dlvReady = 1'b1;
    expectDlv("R12 first out", SRC_BASE + 2, 2, 3);
    expectDlv("R12 second out", SRC_BASE + 3, 3, 4);
    expectNone("R12 drained");

    // R8 asserted follows line
    setLine(4, 1'b0);
    eoi(SRC_BASE + 4);
    resend();
    expectNone("R8 deasserted no offer");
    setLine(4, 1'b1);
    expectDlv("R8 reassert", SRC_BASE + 4, 0, 5);

    // R5 R8 disabled level source offered on enable
    cfg(OP_OFF, SRC_BASE + 6, 0, 0);
    setLine(6, 1'b1);
    expectNone("R8 masked level");
    cfg(OP_ON, SRC_BASE + 6, 0, 0);
    expectDlv("R8 level on enable", SRC_BASE + 6, 2, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule